// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is one bank of general-purpose pins, up to sixteen, with the pin count set by the `NPINS` parameter. Each pin is either an output or an input. An output pin is driven from a latched value. An input pin passes through a two-stage synchroniser, and the synchronised level is what software reads back.

Every pin has its own interrupt detector. A 3-bit mode code selects what the detector looks for: a rising edge, a falling edge, either edge, a high level or a low level. When a pin is enabled, a detected event sets a sticky pending bit. Software clears that bit by writing a one to it. A separate mask, set and cleared through two write-one registers, decides which pending bits reach the single combined interrupt output.

Software reaches the bank through a plain 32-bit register port addressed by word index. A one-cycle soft-reset pulse returns the whole bank to its reset state.

Top module: `gpio_bank`

## Requirements
- R1: After `rst_n` low or a one-cycle `soft_rst` pulse, every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low.
- R2: Word 8 (direction) drives `pin_oe`, where a bit of 1 marks an output. Word 6 (output latch) drives `pin_out`. Bits at or above `NPINS` are dropped on write and read back as zero.
- R3: Word 7 returns the pin levels two clock edges after they are presented on `pin_in`.
- R4: The mode of pin p sits in a 4-bit field at bit 4·p of word 9 for p<8, and at bit 4·(p−8) of word 10 otherwise. Only the low 3 bits are stored, and bit 3 of each field reads back as zero.
- R5: Mode code 1 (rising) sets the pending bit of an enabled pin on a 0→1 transition of its synchronised level.
- R6: Mode code 0 (falling) sets the pending bit on a 1→0 transition and ignores a 0→1 transition.
- R7: Mode code 4 (both edges) sets the pending bit on either transition.
- R8: Mode code 3 (high level) and mode code 2 (low level) set the pending bit while the level holds. A clear written while the level persists leaves the bit set.
- R9: Mode codes 5, 6 and 7 never set a pending bit.
- R10: Word 0 (enable) gates the setting of pending bits. Word 2 shows the raw detector outputs of all pins, whether or not they are enabled.
- R11: Writing 1s to word 3 clears the matching pending bits of word 1 (status). Zero bits leave them unchanged, and word 3 reads zero.
- R12: Writing 1s to word 4 masks pins, and writing 1s to word 5 unmasks them. Both words read the mask. `irq` is the OR of the pending bits that are not masked, and masking does not clear a pending bit.
- R13: Writes to word 11 and above change nothing, and these words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` updates on the same edge |
| addr | input | 4 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Output enable per pin (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
The detectors run with different modes on neighbouring pins at the same time. A single input change must therefore set exactly one pending bit: the falling detector must stay silent on a rise, and the both-edge detector must fire on each direction. Level modes are tested by clearing a pin while its level persists and again after the level goes away, which separates sticky-edge behaviour from re-arming level behaviour. Reserved mode codes are tested with pins toggling in both directions. A disabled pin with an active low level shows that the display word and the status word differ. The mask tests toggle the mask around a pending bit that stays set, so the mask is shown to gate `irq` without clearing status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [3:0] A_EN      = 4'd0;
  localparam logic [3:0] A_STAT    = 4'd1;
  localparam logic [3:0] A_DISP    = 4'd2;
  localparam logic [3:0] A_CLR     = 4'd3;
  localparam logic [3:0] A_MSET    = 4'd4;
  localparam logic [3:0] A_MCLR    = 4'd5;
  localparam logic [3:0] A_OUT     = 4'd6;
  localparam logic [3:0] A_IN      = 4'd7;
  localparam logic [3:0] A_DIR     = 4'd8;
  localparam logic [3:0] A_MODE_LO = 4'd9;
  localparam logic [3:0] A_MODE_HI = 4'd10;

  localparam int MODE_W    = 3;
  localparam int FIELD_W   = 4;
  localparam int PINS_PER_MODE_WORD = 8;

  localparam logic [MODE_W-1:0] DM_FALL = 3'd0;
  localparam logic [MODE_W-1:0] DM_RISE = 3'd1;
  localparam logic [MODE_W-1:0] DM_LOW  = 3'd2;
  localparam logic [MODE_W-1:0] DM_HIGH = 3'd3;
  localparam logic [MODE_W-1:0] DM_BOTH = 3'd4;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] sync_q, sync_d;
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    if (soft_rst) begin
      meta_d = '0;
      sync_d = '0;
      prev_d = '0;
    end else begin
      meta_d = din;
      sync_d = meta_q;
      prev_d = sync_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_det.sv
module gpio_evt_det
  import gpio_bank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              cur,
  input  logic              prev,
  output logic              evt
);
  always_comb begin
    unique case (mode)
      DM_FALL: evt = prev & ~cur;
      DM_RISE: evt = ~prev & cur;
      DM_LOW:  evt = ~cur;
      DM_HIGH: evt = cur;
      DM_BOTH: evt = prev ^ cur;
      default: evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [NPINS-1:0] evt,
  input  logic [NPINS-1:0] en,
  input  logic [NPINS-1:0] wbits,
  input  logic             clr_we,
  input  logic             mset_we,
  input  logic             mclr_we,
  output logic [NPINS-1:0] status_o,
  output logic [NPINS-1:0] mask_o,
  output logic             irq_o
);
  logic [NPINS-1:0] status_q, status_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic [NPINS-1:0] clr_bits, set_bits;

  always_comb begin
    clr_bits = clr_we ? wbits : '0;
    set_bits = evt & en;
    if (soft_rst) begin
      status_d = '0;
      mask_d   = '0;
    end else begin
      status_d = (status_q & ~clr_bits) | set_bits;
      mask_d   = mask_q;
      if (mset_we) mask_d = mask_q | wbits;
      if (mclr_we) mask_d = mask_q & ~wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  localparam int SLOTS = PINS_PER_MODE_WORD;

  logic [NPINS-1:0] en_q, en_d;
  logic [NPINS-1:0] out_q, out_d;
  logic [NPINS-1:0] dir_q, dir_d;
  logic [NPINS-1:0] sync_w, prev_w, evt_w, stat_w, mask_w;
  logic [MODE_W-1:0] mode_vec [NPINS];
  logic [31:0] mode_lo_img, mode_hi_img;
  logic [31:0] rdata_q, rdata_d;
  logic [NPINS-1:0] wbits;

  assign wbits = wdata[NPINS-1:0];

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .din(pin_in), .sync_o(sync_w), .prev_o(prev_w)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    localparam int FP = (g < SLOTS) ? FIELD_W * g : FIELD_W * (g - SLOTS);
    localparam logic [3:0] MSEL = (g < SLOTS) ? A_MODE_LO : A_MODE_HI;
    logic [MODE_W-1:0] mode_q, mode_d;

    always_comb begin
      mode_d = mode_q;
      if (soft_rst) mode_d = '0;
      else if (wr_en && addr == MSEL) mode_d = wdata[FP +: MODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= '0;
      else        mode_q <= mode_d;
    end

    assign mode_vec[g] = mode_q;

    gpio_evt_det u_det (
      .mode(mode_q), .cur(sync_w[g]), .prev(prev_w[g]), .evt(evt_w[g])
    );
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_img
    if (s < NPINS) begin : g_lo
      assign mode_lo_img[FIELD_W*s +: FIELD_W] = {1'b0, mode_vec[s]};
    end else begin : g_lo0
      assign mode_lo_img[FIELD_W*s +: FIELD_W] = '0;
    end
    if (s + SLOTS < NPINS) begin : g_hi
      assign mode_hi_img[FIELD_W*s +: FIELD_W] = {1'b0, mode_vec[s+SLOTS]};
    end else begin : g_hi0
      assign mode_hi_img[FIELD_W*s +: FIELD_W] = '0;
    end
  end

  gpio_irq_status #(.NPINS(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .evt(evt_w), .en(en_q), .wbits(wbits),
    .clr_we(wr_en && addr == A_CLR),
    .mset_we(wr_en && addr == A_MSET),
    .mclr_we(wr_en && addr == A_MCLR),
    .status_o(stat_w), .mask_o(mask_w), .irq_o(irq)
  );

  always_comb begin
    en_d  = en_q;
    out_d = out_q;
    dir_d = dir_q;
    if (soft_rst) begin
      en_d  = '0;
      out_d = '0;
      dir_d = '0;
    end else if (wr_en) begin
      if (addr == A_EN)  en_d  = wbits;
      if (addr == A_OUT) out_d = wbits;
      if (addr == A_DIR) dir_d = wbits;
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (soft_rst) begin
      rdata_d = '0;
    end else if (rd_en) begin
      case (addr)
        A_EN:      rdata_d = 32'(en_q);
        A_STAT:    rdata_d = 32'(stat_w);
        A_DISP:    rdata_d = 32'(evt_w);
        A_MSET,
        A_MCLR:    rdata_d = 32'(mask_w);
        A_OUT:     rdata_d = 32'(out_q);
        A_IN:      rdata_d = 32'(sync_w);
        A_DIR:     rdata_d = 32'(dir_q);
        A_MODE_LO: rdata_d = mode_lo_img;
        A_MODE_HI: rdata_d = mode_hi_img;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      out_q   <= '0;
      dir_q   <= '0;
      rdata_q <= '0;
    end else begin
      en_q    <= en_d;
      out_q   <= out_d;
      dir_q   <= dir_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata   = rdata_q;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             wr_en,
  input logic [3:0]       addr,
  input logic [31:0]      wdata,
  input logic [NPINS-1:0] pin_oe,
  input logic [NPINS-1:0] status,
  input logic [NPINS-1:0] en,
  input logic             irq
);
  // R1
  soft_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pin_oe == '0 && !irq));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !(wr_en && addr == A_DIR)) |=> $stable(pin_oe));

  // R10
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((status & ~$past(status) & ~$past(en)) == '0));

  // R12
  full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && wr_en && addr == A_MSET && wdata[NPINS-1:0] == {NPINS{1'b1}})
    |=> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .pin_oe(pin_oe), .status(stat_w),
  .en(en_q), .irq(irq)
);

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
  localparam int NP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq;

  always #10 clk = ~clk;

  gpio_bank #(.NPINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb_q[$];
  int n_total = 0;
  int n_fail  = 0;
  logic rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      n_total++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: read data %h with no expected item", rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (rdata !== e.val) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected %h", e.tag, rdata, e.val);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.val = e; it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_total++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: value=%h expected %h", tag, act, e);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_total++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    rd(0, 32'h0, "R1 enable");
    rd(8, 32'h0, "R1 direction");
    rd(9, 32'h0, "R1 mode lo");
    chk(32'(pin_oe), 32'h0, "R1 pin_oe");
    chk(32'(irq), 32'h0, "R1 irq");

    // R2 direction and output latch, upper bits dropped
    wr(8, 32'hFFFF_FFFF);
    rd(8, 32'h0000_0FFF, "R2 direction readback");
    chk(32'(pin_oe), 32'hFFF, "R2 pin_oe");
    wr(6, 32'h0000_FA5A);
    chk(32'(pin_out), 32'hA5A, "R2 pin_out");
    rd(6, 32'h0000_0A5A, "R2 latch readback");
    wr(8, 32'h0000_000F);
    chk(32'(pin_oe), 32'h00F, "R2 pin_oe partial");

    // R3 synchronised input view
    pin_in = 12'h3C3;
    tick(3);
    rd(7, 32'h0000_03C3, "R3 input levels");

    // R4 mode field layout
    wr(9, 32'hFFFF_FFFF);
    rd(9, 32'h7777_7777, "R4 mode lo all ones");
    wr(10, 32'hFFFF_FFFF);
    rd(10, 32'h0000_7777, "R4 mode hi limited to pins 8-11");
    wr(9, 32'h9876_5432);
    rd(9, 32'h1076_5432, "R4 bit3 dropped");

    // interrupt setup: p0 rise, p1 fall, p2 both, p3 high, p4 low, p5-7 code 7
    pin_in = '0;
    tick(3);
    wr(9, 32'h7772_3401);
    wr(10, 32'h0000_5765);
    wr(0, 32'h0000_0F0F);
    wr(3, 32'h0000_0FFF);
    tick(2);
    rd(1, 32'h0, "R10 status empty with disabled low pin");
    rd(2, 32'h0000_0010, "R10 display shows raw low-level event");

    // R5 rising
    pin_in = 12'h001; tick(4);
    rd(1, 32'h0000_0001, "R5 rise sets pin0");
    // R6 falling
    pin_in = 12'h003; tick(4);
    rd(1, 32'h0000_0001, "R6 rise ignored on falling pin");
    pin_in = 12'h001; tick(4);
    rd(1, 32'h0000_0003, "R6 fall sets pin1");
    // R7 both edges
    pin_in = 12'h005; tick(4);
    rd(1, 32'h0000_0007, "R7 rise sets pin2");
    wr(3, 32'h0000_0004);
    rd(1, 32'h0000_0003, "R11 clear pin2 only");
    pin_in = 12'h001; tick(4);
    rd(1, 32'h0000_0007, "R7 fall sets pin2");
    // R11 zero write, full clear
    wr(3, 32'h0);
    rd(1, 32'h0000_0007, "R11 zero clear no effect");
    rd(3, 32'h0, "R11 clear word reads zero");
    wr(3, 32'h0000_0007);
    rd(1, 32'h0, "R11 clear all");

    // R8 level modes
    pin_in = 12'h009; tick(4);
    rd(1, 32'h0000_0008, "R8 high level sets pin3");
    wr(3, 32'h0000_0008);
    rd(1, 32'h0000_0008, "R8 high level re-sets after clear");
    pin_in = 12'h001; tick(4);
    wr(3, 32'h0000_0008);
    rd(1, 32'h0, "R8 clear sticks once level gone");
    wr(0, 32'h0000_0F1F);
    tick(2);
    rd(1, 32'h0000_0010, "R8 low level sets pin4");
    pin_in = 12'h011; tick(4);
    wr(3, 32'h0000_0010);
    rd(1, 32'h0, "R8 low level cleared after release");

    // R9 reserved codes on pins 8-11
    pin_in = 12'hF11; tick(4);
    pin_in = 12'h011; tick(4);
    rd(1, 32'h0, "R9 codes 5-7 never set");

    // R12 mask
    pin_in = 12'h019; tick(4);
    chk(32'(irq), 32'h1, "R12 irq from pending pin3");
    wr(4, 32'h0000_0008);
    chk(32'(irq), 32'h0, "R12 masked");
    rd(1, 32'h0000_0008, "R12 mask keeps status");
    rd(4, 32'h0000_0008, "R12 mask readback");
    wr(5, 32'h0);
    chk(32'(irq), 32'h0, "R12 zero unmask no effect");
    wr(5, 32'h0000_0008);
    chk(32'(irq), 32'h1, "R12 unmask restores irq");

    // R13 reserved word
    wr(11, 32'hFFFF_FFFF);
    rd(11, 32'h0, "R13 reserved reads zero");
    rd(0, 32'h0000_0F1F, "R13 enable untouched");
    rd(8, 32'h0000_000F, "R13 direction untouched");
    chk(32'(irq), 32'h1, "R13 irq untouched");

    // R1 soft reset
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(32'(pin_oe), 32'h0, "R1 soft reset pin_oe");
    chk(32'(pin_out), 32'h0, "R1 soft reset pin_out");
    chk(32'(irq), 32'h0, "R1 soft reset irq");
    tick(2);
    rd(0, 32'h0, "R1 soft reset enable");
    rd(9, 32'h0, "R1 soft reset mode");
    rd(4, 32'h0, "R1 soft reset mask");
    rd(1, 32'h0, "R1 soft reset status");
    tick(3);
    summary();
  end
endmodule